// File: doc/BRIEF.md
# Decade Counter with Decoded Clear

A synchronous binary counter that steps through the codes 0 to 9 and then returns to 0. It does not compare the whole value against a limit. It ANDs together only the bits that are set in the wrap code. For the default wrap code of ten, these are bit 3 and bit 1. When that partial decode sees the code that would follow the last value, it produces an active-low internal clear. That clear loads zero into every state bit on the same clock edge. As a result, the codes from ten to fifteen never reach the outputs, not even for one cycle.

The wrap code is a parameter, so the same structure builds other moduli. For example, a wrap code of six decodes bits 2 and 1 and gives a divide-by-six counter. No code below the wrap code can have all of the wrap code's set bits high, so the partial decode always fires first at exactly the wrap code. An elaboration check keeps the wrap code between 2 and 2^WIDTH. A generate option can replace the partial decode with a full equality compare.

The counter has two controls. A count enable lets the value advance. An active-low external clear resets the value asynchronously and overrides the enable. A terminal flag is high while the value is the last one before the wrap. This flag can be used to chain further digits ahead of a display decoder.

Top module: `dec_clr_counter`

## Requirements
- R1: With `cnt_en` high, each rising clock edge advances `count_q` by one, from 0 up to 9. The edge after 9 returns it to 0.
- R2: `count_q` never shows a value of ten or more. With `WIDTH`=4, the codes 10 to 15 never appear.
- R3: The wrap is found by a partial decode of the incremented value. Only the bits set in `MOD_CODE` are ANDed, which for the default are bit 3 and bit 1. The decoded clear loads 0 on the same edge that would otherwise have produced the wrap code.
- R4: `count_q[0]` is the least significant bit. With the default even modulus, it toggles on every counted edge.
- R5: While `cnt_en` is low, clock edges leave `count_q` unchanged.
- R6: Driving `clr_n` low forces `count_q` to 0 immediately, without waiting for a clock edge, whatever the state of `cnt_en`. The value stays 0 while `clr_n` is held low.
- R7: `term_o` is high exactly while `count_q` equals `MOD_CODE`-1, which is 9 for the default.
- R8: Setting `MOD_CODE` to another value gives a counter of that modulus, built from the same decode structure. With `MOD_CODE`=6, the value counts 0 to 5 and then returns to 0, and `term_o` is high at 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; the value changes on the rising edge |
| clr_n | input | 1 | External clear, active low, asynchronous |
| cnt_en | input | 1 | Count enable, active high |
| count_q | output | WIDTH | Present count, bit 0 least significant |
| term_o | output | 1 | High while the count is at its last value |

## Verification
On every cycle, the assertions check the following:
- the value stays below the modulus;
- an enabled edge adds exactly one except from the last value;
- the last value is always followed by zero;
- a disabled edge holds the value;
- the terminal flag never lasts across an enabled edge;
- the decoded clear fires only when the probe equals the wrap code.

Some behaviour is shown only by the bench's scenarios:
- the clear acting between clock edges;
- the exact cycle-by-cycle sequence from a known start;
- that the terminal flag marks the value nine and no other;
- that a second modulus built from a different decode set actually counts to five and wraps.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   // Selects how the wrap code is recognised.
   typedef enum logic {
      DEC_PARTIAL = 1'b0,   // AND of the bits that are set in the wrap code
      DEC_FULL    = 1'b1    // full equality compare against the wrap code
   } dec_style_e;

   // Number of set bits in a code; used to size the decode report.
   function automatic int unsigned ones_in(input int unsigned code);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) begin
         if (code[i]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/dcc_step.sv
module dcc_step #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH:0]   nxt_o
);

   // One bit wider than the state, so that a wrap code of 2^WIDTH is reachable.
   always_comb begin
      nxt_o = {1'b0, cur_i} + {{WIDTH{1'b0}}, 1'b1};
   end

endmodule

// File: rtl/dcc_wrap_decode.sv
module dcc_wrap_decode
   import dcc_pkg::*;
#(
   parameter int unsigned WIDTH    = 4,
   parameter int unsigned MOD_CODE = 10,
   parameter dec_style_e  STYLE    = DEC_PARTIAL
) (
   input  logic [WIDTH:0] probe_i,
   output logic           wrap_clr_n_o
);

   localparam logic [WIDTH:0] WRAP_PAT = (WIDTH+1)'(MOD_CODE);
   localparam int unsigned    TAP_CNT  = ones_in(MOD_CODE);

   generate
      if (STYLE == DEC_PARTIAL) begin : g_partial
         // Bits outside the pattern are forced high; only the tapped bits
         // decide. For the default pattern this is bit3 AND bit1.
         logic [WIDTH:0] taps;
         always_comb begin
            taps         = probe_i | ~WRAP_PAT;
            wrap_clr_n_o = ~(&taps);
         end
         if (TAP_CNT < 1) begin : g_no_taps
            $error("dcc_wrap_decode: wrap pattern has no set bits");
         end
      end else begin : g_full
         always_comb begin
            wrap_clr_n_o = (probe_i != WRAP_PAT);
         end
      end
   endgenerate

endmodule

// File: rtl/dcc_state.sv
module dcc_state #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             cnt_en,
   input  logic             wrap_clr_n,
   input  logic [WIDTH-1:0] nxt_i,
   output logic [WIDTH-1:0] q_o
);

   // Asynchronous external clear; the decoded clear acts synchronously and
   // loads zero in place of the wrap code.
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         q_o <= '0;
      end else if (cnt_en) begin
         q_o <= wrap_clr_n ? nxt_i : '0;
      end
   end

endmodule

// File: rtl/dec_clr_counter.sv
module dec_clr_counter
   import dcc_pkg::*;
#(
   parameter int unsigned WIDTH    = 4,
   parameter int unsigned MOD_CODE = 10,
   parameter dec_style_e  STYLE    = DEC_PARTIAL
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             cnt_en,
   output logic [WIDTH-1:0] count_q,
   output logic             term_o
);

   localparam int unsigned   SPAN     = 1 << WIDTH;
   localparam logic [WIDTH:0] MOD_W   = (WIDTH+1)'(MOD_CODE);
   localparam logic [WIDTH-1:0] LAST_V = WIDTH'(MOD_CODE - 1);

   generate
      if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
         $error("dec_clr_counter: WIDTH must lie in 1..16");
      end
      if (MOD_CODE < 2 || MOD_CODE > SPAN) begin : g_bad_mod
         $error("dec_clr_counter: MOD_CODE must lie in 2..2^WIDTH");
      end
   endgenerate

   logic [WIDTH:0] nxt;
   logic           wrap_clr_n;

   dcc_step #(.WIDTH(WIDTH)) step_i (
      .cur_i (count_q),
      .nxt_o (nxt)
   );

   dcc_wrap_decode #(.WIDTH(WIDTH), .MOD_CODE(MOD_CODE), .STYLE(STYLE)) dec_i (
      .probe_i      (nxt),
      .wrap_clr_n_o (wrap_clr_n)
   );

   dcc_state #(.WIDTH(WIDTH)) state_i (
      .clk        (clk),
      .clr_n      (clr_n),
      .cnt_en     (cnt_en),
      .wrap_clr_n (wrap_clr_n),
      .nxt_i      (nxt[WIDTH-1:0]),
      .q_o        (count_q)
   );

   // The decoded clear is armed exactly when the next code would be the wrap
   // code, i.e. while sitting on the last value.
   assign term_o = ~wrap_clr_n;

   // ---------------- assertions ----------------
   p_range_r2: assert property (@(posedge clk) disable iff (!clr_n)
      {1'b0, count_q} < MOD_W);

   p_step_r1: assert property (@(posedge clk) disable iff (!clr_n)
      (cnt_en && count_q != LAST_V) |=> (count_q == $past(count_q) + 1'b1));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!clr_n)
      (cnt_en && count_q == LAST_V) |=> (count_q == '0));

   p_decode_r3: assert property (@(posedge clk) disable iff (!clr_n)
      !wrap_clr_n |-> (nxt == MOD_W));

   p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
      !cnt_en |=> $stable(count_q));

   p_term_r7: assert property (@(posedge clk) disable iff (!clr_n)
      (cnt_en && term_o) |=> !term_o);

   generate
      if (MOD_CODE % 2 == 0) begin : g_even_chk
         p_lsb_r4: assert property (@(posedge clk) disable iff (!clr_n)
            cnt_en |=> (count_q[0] != $past(count_q[0])));
      end
   endgenerate

endmodule

// File: tb/dec_clr_counter_tb_top.sv
module dec_clr_counter_tb_top;

   logic       clk = 1'b0;
   logic       clr_n;
   logic       cnt_en;
   logic [3:0] cq, cq6;
   logic       tm, tm6;
   int         checks = 0;
   int         errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   dec_clr_counter dut_i (
      .clk(clk), .clr_n(clr_n), .cnt_en(cnt_en), .count_q(cq), .term_o(tm));

   dec_clr_counter #(.MOD_CODE(6)) dut6_i (
      .clk(clk), .clr_n(clr_n), .cnt_en(cnt_en), .count_q(cq6), .term_o(tm6));

   // {en, clr_n, expected count[3:0], expected term} after one edge
   localparam logic [6:0] VEC [17] = '{
      {1'b1, 1'b1, 4'd1, 1'b0},
      {1'b1, 1'b1, 4'd2, 1'b0},
      {1'b1, 1'b1, 4'd3, 1'b0},
      {1'b1, 1'b1, 4'd4, 1'b0},
      {1'b1, 1'b1, 4'd5, 1'b0},
      {1'b1, 1'b1, 4'd6, 1'b0},
      {1'b1, 1'b1, 4'd7, 1'b0},
      {1'b1, 1'b1, 4'd8, 1'b0},
      {1'b1, 1'b1, 4'd9, 1'b1},
      {1'b1, 1'b1, 4'd0, 1'b0},
      {1'b0, 1'b1, 4'd0, 1'b0},
      {1'b1, 1'b1, 4'd1, 1'b0},
      {1'b0, 1'b1, 4'd1, 1'b0},
      {1'b1, 1'b1, 4'd2, 1'b0},
      {1'b1, 1'b0, 4'd0, 1'b0},
      {1'b0, 1'b0, 4'd0, 1'b0},
      {1'b1, 1'b1, 4'd1, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      summary();
      $finish;
   end

   initial begin
      int m10, m6, prev0;
      clr_n  = 1'b0;
      cnt_en = 1'b0;
      #20;
      chk("R6 reset count", cq, 0);
      chk("R7 reset term", tm, 0);
      @(negedge clk);
      clr_n = 1'b1;

      // table walk
      for (int i = 0; i < 17; i++) begin
         cnt_en = VEC[i][6];
         clr_n  = VEC[i][5];
         @(negedge clk);
         chk($sformatf("R1 vec %0d count", i), cq, int'(VEC[i][4:1]));
         chk($sformatf("R7 vec %0d term", i), tm, int'(VEC[i][0]));
      end

      // asynchronous clear between edges, enable high (count is 1 here)
      cnt_en = 1'b1;
      @(negedge clk);
      chk("R1 pre-clear count", cq, 2);
      #1 clr_n = 1'b0;
      #1;
      chk("R6 async clear", cq, 0);
      chk("R8 async clear mod6", cq6, 0);
      @(negedge clk);
      chk("R6 clear held", cq, 0);
      clr_n = 1'b1;

      // long sweep over both moduli
      m10 = 0; m6 = 0; prev0 = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         m10 = (m10 + 1) % 10;
         m6  = (m6 + 1) % 6;
         chk("R1 sweep count", cq, m10);
         chk("R2 sweep range", (cq <= 4'd9) ? 1 : 0, 1);
         chk("R4 lsb toggles", cq[0], 1 - prev0);
         prev0 = cq[0];
         chk("R7 sweep term", tm, (m10 == 9) ? 1 : 0);
         if (m10 == 0) chk("R3 wrap to zero", cq, 0);
         chk("R8 mod6 count", cq6, m6);
         chk("R8 mod6 term", tm6, (m6 == 5) ? 1 : 0);
      end

      // hold with enable low
      cnt_en = 1'b0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk("R5 hold count", cq, m10);
         chk("R5 hold mod6", cq6, m6);
      end

      // resume to last value and confirm the wrap edge
      cnt_en = 1'b1;
      while (m10 != 9) begin
         @(negedge clk);
         m10 = (m10 + 1) % 10;
         m6  = (m6 + 1) % 6;
      end
      chk("R7 at nine term", tm, 1);
      chk("R1 at nine count", cq, 9);
      @(negedge clk);
      chk("R3 nine wraps", cq, 0);
      chk("R2 no ten", (cq == 4'd10) ? 1 : 0, 0);

      summary();
      $finish;
   end

endmodule